// File: doc/BRIEF.md
# Rotating Bank-Schedule Processing Array

This block runs a group of processing elements (PEs) that all read one kernel array split across as many single-port banks as there are PEs. Kernel element `e` lives in bank `e mod NUM_PE` at word `e div NUM_PE`, so neighbouring elements sit in different banks. Each PE accumulates one partition of the image partial sum. A scheduler walks through `NUM_PE` stages. In each stage it hands every PE a different bank, so no bank ever sees two readers in one cycle. Every PE still reaches every bank once, which covers the kernel data that lies outside its own partition.

A pulse on `start_i` clears all partial sums and opens stage 0. While a stage is open, a PE raises its accumulate enable to read a word, at an offset it supplies, from the bank it is currently assigned. The word is multiplied by the PE's coefficient and added to its partial sum. When a PE has finished the stage it pulses its stage-complete input. The stage moves on only after all PEs have reported. A one-cycle `done_o` marks the end of the last stage. Kernel bank reads are combinational: the data for an address comes back in the same cycle.

Top module: `rot_bank_array`

## Requirements
- R1: While reset is held and right after it, `done_o` is 0, every `bank_re_o` bit is 0 and every `psum_o` entry is 0.
- R2: `start_i` is accepted only while idle. The cycle after it is accepted, every `psum_o` entry reads 0 and stage 0 is open. A `start_i` during an operation has no effect.
- R3: In stage s, PE p is served by bank (p + s) mod NUM_PE. That bank's `bank_re_o` bit is high exactly when the PE has an active request, and its `bank_addr_o` carries the PE's `off_i`. No bank is ever assigned to two PEs.
- R4: A PE with an active request adds, unsigned, `bank_rdata_i` of its bank times its `coef_i` to its partial sum. The new sum is visible the cycle after. A PE with no request keeps its sum.
- R5: A `stage_done_i` pulse marks the PE finished for the current stage. The stage advances at the edge where all PEs are marked, counting pulses in that same cycle. Until then, a finished PE's `acc_en_i` is ignored: its bank is not read and its sum does not change.
- R6: `done_o` is high for exactly one cycle, the cycle after stage NUM_PE-1 completes. The block is then idle and the partial sums hold their values.
- R7: While idle, `acc_en_i` is ignored and no bank read is issued.
- R8: Any NUM_PE of 2 or more is supported, including the non-power-of-two 25 of a 5-by-5 split. The bank index wraps by modulo and not by bit truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (idle only) |
| done_o | output | 1 | One-cycle pulse after the last stage |
| acc_en_i | input | NUM_PE | Per-PE accumulate request |
| off_i | input | NUM_PE x ADDR_W | Per-PE word offset within its assigned bank |
| coef_i | input | NUM_PE x COEF_W | Per-PE multiplier |
| stage_done_i | input | NUM_PE | Per-PE stage-complete pulse |
| bank_re_o | output | NUM_PE | Per-bank read enable |
| bank_addr_o | output | NUM_PE x ADDR_W | Per-bank read address |
| bank_rdata_i | input | NUM_PE x DATA_W | Per-bank read data, same cycle |
| psum_o | output | NUM_PE x ACC_W | Per-PE partial sum |

## Verification
The bench runs with 25 PEs and drives three input patterns.

- **Sparse random completion.** Requests and completions arrive at random, so stages last many cycles with mixed finished and unfinished PEs. This separates a scheduler that waits for every PE from one that advances early, and it exercises the ignored requests of finished PEs.
- **Saturated completion.** Every PE reports done every cycle, so each stage lasts one cycle. This tells apart same-cycle completion counting from a design that only counts flags registered earlier.
- **Maximum operands.** Coefficients and data at their maximum values expose truncated products.

Across the stages, the bank and address seen on each read port separate a true modulo wrap from power-of-two masking. Directed steps also cover idle requests, a start pulse raised mid-operation, and the `done_o` pulse.

// File: rtl/rot_bank_pkg.sv
`timescale 1ns/1ps
package rot_bank_pkg;
  // bank served to a PE in a stage
  function automatic int rot_fwd(int pe, int stg, int n);
    int s;
    s = pe + stg;
    return (s >= n) ? s - n : s;
  endfunction
  // PE served by a bank in a stage
  function automatic int rot_back(int bank, int stg, int n);
    return (bank >= stg) ? bank - stg : bank + n - stg;
  endfunction
endpackage

// File: rtl/rot_sched.sv
`timescale 1ns/1ps
module rot_sched #(
  parameter int NUM_PE = 4,
  localparam int PW = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_PE-1:0] stage_done_i,
  output logic              busy_o,
  output logic [PW-1:0]     stage_o,
  output logic [NUM_PE-1:0] fin_o,
  output logic              clr_o,
  output logic              done_o
);
  logic              busy_q, done_q;
  logic [PW-1:0]     stage_q;
  logic [NUM_PE-1:0] fin_q, fin_nx;
  logic              all_fin;

  assign fin_nx  = fin_q | stage_done_i;
  assign all_fin = &fin_nx;
  assign clr_o   = !busy_q && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stage_q <= '0;
      fin_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          stage_q <= '0;
          fin_q   <= '0;
        end
      end else if (all_fin) begin
        fin_q <= '0;
        if (stage_q == PW'(NUM_PE - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          stage_q <= stage_q + 1'b1;
        end
      end else begin
        fin_q <= fin_nx;
      end
    end
  end

  assign busy_o  = busy_q;
  assign stage_o = stage_q;
  assign fin_o   = fin_q;
  assign done_o  = done_q;

  assert_stage_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !(&(fin_q | stage_done_i))) |=> (busy_q && $stable(stage_q)));
  assert_done_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && stage_q == PW'(NUM_PE - 1) && (&(fin_q | stage_done_i))) |=> (done_q && !busy_q));
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !(&(fin_q | stage_done_i))) |=> $stable(stage_q));
endmodule

// File: rtl/rot_xbar.sv
`timescale 1ns/1ps
module rot_xbar
  import rot_bank_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int PW = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           busy_i,
  input  logic [PW-1:0]                  stage_i,
  input  logic [NUM_PE-1:0]              req_i,
  input  logic [NUM_PE-1:0][ADDR_W-1:0]  off_i,
  input  logic [NUM_PE-1:0][DATA_W-1:0]  bank_rdata_i,
  output logic [NUM_PE-1:0]              bank_re_o,
  output logic [NUM_PE-1:0][ADDR_W-1:0]  bank_addr_o,
  output logic [NUM_PE-1:0][DATA_W-1:0]  pe_data_o
);
  logic [NUM_PE-1:0][PW-1:0] sel;

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    assign sel[p]       = PW'(rot_fwd(p, int'(stage_i), NUM_PE));
    assign pe_data_o[p] = bank_rdata_i[sel[p]];
  end

  for (genvar b = 0; b < NUM_PE; b++) begin : g_bank
    logic [PW-1:0]     owner;
    logic [NUM_PE-1:0] hit;
    assign owner          = PW'(rot_back(b, int'(stage_i), NUM_PE));
    assign bank_re_o[b]   = req_i[owner];
    assign bank_addr_o[b] = off_i[owner];
    for (genvar q = 0; q < NUM_PE; q++) begin : g_hit
      assign hit[q] = (sel[q] == PW'(b));
    end

    assert_one_reader_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i |-> ($countones(hit) == 1));
    assert_owner_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_re_o[b] |-> (sel[owner] == PW'(b)));
  end
endmodule

// File: rtl/rot_pe.sv
`timescale 1ns/1ps
module rot_pe #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 40,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_q;

  assign prod = data_i * coef_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + ACC_W'(prod);
  end

  assign acc_o = acc_q;

  assert_clr_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_o == '0));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(acc_o));
endmodule

// File: rtl/rot_bank_array.sv
`timescale 1ns/1ps
module rot_bank_array #(
  parameter int NUM_PE = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 40,
  localparam int PW = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  output logic                          done_o,
  input  logic [NUM_PE-1:0]             acc_en_i,
  input  logic [NUM_PE-1:0][ADDR_W-1:0] off_i,
  input  logic [NUM_PE-1:0][COEF_W-1:0] coef_i,
  input  logic [NUM_PE-1:0]             stage_done_i,
  output logic [NUM_PE-1:0]             bank_re_o,
  output logic [NUM_PE-1:0][ADDR_W-1:0] bank_addr_o,
  input  logic [NUM_PE-1:0][DATA_W-1:0] bank_rdata_i,
  output logic [NUM_PE-1:0][ACC_W-1:0]  psum_o
);
  logic                          busy, clr;
  logic [PW-1:0]                 stage;
  logic [NUM_PE-1:0]             fin, req;
  logic [NUM_PE-1:0][DATA_W-1:0] pe_data;

  // finished PEs and idle state drop their requests
  assign req = acc_en_i & ~fin & {NUM_PE{busy}};

  rot_sched #(.NUM_PE(NUM_PE)) u_sched (
    .clk_i, .rst_ni, .start_i, .stage_done_i,
    .busy_o(busy), .stage_o(stage), .fin_o(fin), .clr_o(clr), .done_o
  );

  rot_xbar #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xbar (
    .clk_i, .rst_ni, .busy_i(busy), .stage_i(stage), .req_i(req), .off_i,
    .bank_rdata_i, .bank_re_o, .bank_addr_o, .pe_data_o(pe_data)
  );

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    rot_pe #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_pe (
      .clk_i, .rst_ni, .clr_i(clr), .en_i(req[p]),
      .data_i(pe_data[p]), .coef_i(coef_i[p]), .acc_o(psum_o[p])
    );
  end

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (bank_re_o == '0));
  assert_read_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> ($countones(bank_re_o) == $countones(acc_en_i & ~fin)));
endmodule

// File: tb/rot_bank_array_tb.sv
`timescale 1ns/1ps
module rot_bank_array_tb;
  localparam int N  = 25;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int AC = 40;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic start_i, done_o;
  logic [N-1:0]         acc_en, stage_done, bank_re;
  logic [N-1:0][AW-1:0] off, bank_addr;
  logic [N-1:0][CW-1:0] coef;
  logic [N-1:0][DW-1:0] bank_rdata;
  logic [N-1:0][AC-1:0] psum;
  logic [DW-1:0] mem [N][1<<AW];

  always #10 clk_i = ~clk_i;

  rot_bank_array #(.NUM_PE(N), .ADDR_W(AW), .DATA_W(DW), .COEF_W(CW), .ACC_W(AC)) u_dut (
    .clk_i, .rst_ni, .start_i, .done_o, .acc_en_i(acc_en), .off_i(off), .coef_i(coef),
    .stage_done_i(stage_done), .bank_re_o(bank_re), .bank_addr_o(bank_addr),
    .bank_rdata_i(bank_rdata), .psum_o(psum)
  );

  always_comb
    for (int b = 0; b < N; b++) bank_rdata[b] = mem[b][bank_addr[b]];

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  // model state
  bit m_busy, m_done, m_clr;
  int m_stage;
  bit [N-1:0] m_fin, m_ign;
  logic [AC-1:0] m_psum [N];

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int fwd(int p, int s);
    return (p + s) % N;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // compare outputs, then advance model with current inputs, then clock
  task automatic step();
    #2;
    chk("R6 done_o", done_o, m_done);
    for (int b = 0; b < N; b++) begin
      bit er; int ea; string tg;
      er = 0; ea = 0; tg = m_busy ? "R3 bank read" : "R7 idle read";
      for (int p = 0; p < N; p++)
        if (m_busy && acc_en[p] && !m_fin[p] && fwd(p, m_stage) == b) begin
          er = 1; ea = off[p];
          if (p + m_stage >= N) tg = "R8 wrapped bank read";
        end
      chk(tg, bank_re[b], er);
      if (er) chk(tg, bank_addr[b], ea);
    end
    for (int p = 0; p < N; p++)
      chk(m_clr ? "R2 psum cleared" : (m_ign[p] ? "R5 ignored request" : "R4 psum"),
          psum[p], m_psum[p]);
    m_clr = 0;
    m_ign = '0;
    if (!m_busy) begin
      m_done = 0;
      if (start_i) begin
        m_busy = 1; m_stage = 0; m_fin = '0; m_clr = 1;
        for (int p = 0; p < N; p++) m_psum[p] = '0;
      end
    end else begin
      bit [N-1:0] nf;
      m_done = 0;
      for (int p = 0; p < N; p++) begin
        if (acc_en[p] && m_fin[p]) m_ign[p] = 1;
        if (acc_en[p] && !m_fin[p])
          m_psum[p] = m_psum[p] + AC'(mem[fwd(p, m_stage)][off[p]]) * AC'(coef[p]);
      end
      nf = m_fin | stage_done;
      if (&nf) begin
        m_fin = '0;
        if (m_stage == N - 1) begin m_busy = 0; m_done = 1; end
        else m_stage++;
      end else m_fin = nf;
    end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic drive(int en_pct, int dn_pct, bit maxv);
    for (int p = 0; p < N; p++) begin
      acc_en[p]     = ($urandom % 100) < en_pct;
      stage_done[p] = ($urandom % 100) < dn_pct;
      off[p]        = AW'($urandom);
      coef[p]       = maxv ? '1 : CW'($urandom);
    end
  endtask

  task automatic run_op(int en_pct, int dn_pct, bit maxv, bit poke_start);
    int guard = 0;
    start_i = 1; drive(en_pct, 0, maxv); step(); start_i = 0;
    while (m_busy && guard < 4000) begin
      drive(en_pct, dn_pct, maxv);
      start_i = poke_start && ($urandom % 8 == 0);  // R2: ignored while busy
      step(); guard++;
    end
    start_i = 0; acc_en = '0; stage_done = '0;
    step(); step();  // done pulse then idle hold (R6)
  endtask

  initial begin
    void'($urandom(32'h5EED_0A11));
    for (int b = 0; b < N; b++)
      for (int a = 0; a < (1 << AW); a++) mem[b][a] = DW'($urandom);
    rst_ni = 0; start_i = 0; acc_en = '0; stage_done = '0; off = '0; coef = '0;
    m_busy = 0; m_done = 0; m_clr = 0; m_stage = 0; m_fin = '0; m_ign = '0;
    for (int p = 0; p < N; p++) m_psum[p] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 done_o", done_o, 0);
    chk("R1 bank_re", bank_re, 0);
    for (int p = 0; p < N; p++) chk("R1 psum", psum[p], 0);
    rst_ni = 1;
    @(negedge clk_i);
    // R7 idle requests
    for (int i = 0; i < 4; i++) begin acc_en = '1; stage_done = '1; step(); end
    // sparse random completion with mid-run start pulses
    run_op(70, 20, 0, 1);
    // saturated completion: one-cycle stages
    run_op(100, 100, 0, 0);
    // maximum operands
    for (int b = 0; b < N; b++) mem[b][(1<<AW)-1] = '1;
    run_op(100, 30, 1, 1);
    run_op(50, 40, 0, 0);
    finish_run();
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule